// File: doc/BRIEF.md
# Static Route Mesh Switch

This block is a circuit-switched node in a mesh of a spatial accelerator fabric. It has five port groups: north, east, south and west neighbours plus one local port towards a compute or memory block. Each group carries `LINKS` parallel links. Every link is a word-wide channel with valid/ready handshaking. Each output link takes its word from one input link, and that choice is a routing table entry written before the fabric runs. Because several outputs may name the same input, a broadcast tree can branch at this node.

Flow control works hop by hop. Each output has a one-entry register slice. A hop therefore costs one cycle and can still pass a word every cycle. An input that feeds several outputs hands over a word only in a cycle where every one of those outputs can take it, and all of them take it in that same cycle.

Configuration is written through a small address/data port while `cfg_mode` holds the fabric idle. While `cfg_mode` is low the routing table is frozen.

Top module: `mesh_route_switch`

## Requirements
- R1: After reset every output has no valid word, every routing entry is disabled, and every `in_ready` is low.
- R2: Link numbering is `group*LINKS + link`, with groups north=0, east=1, south=2, west=3 and local=4, for both inputs and outputs. A write with `cfg_mode` and `cfg_we` high, at an address below the output count, sets the entry of output `cfg_addr`. In `cfg_wdata`, bit `SELW` is the enable and bits `SELW-1:0` are the source input index. The entry applies from the next cycle.
- R3: A configuration write while `cfg_mode` is low has no effect on routing.
- R4: While `cfg_mode` is high every `in_ready` is low and no word is accepted.
- R5: An output whose entry is disabled never drives `out_valid`. An input that no enabled output selects keeps `in_ready` low.
- R6: A word accepted on an input appears on each of its destination outputs one cycle later, with its data unchanged.
- R7: For an input with destinations, `in_ready` is high only when every destination slice is empty or being drained that cycle. The word is consumed once and is loaded into all destinations in the same cycle.
- R8: An output with `out_valid` high and `out_ready` low keeps `out_valid` high and `out_data` unchanged in the next cycle.
- R9: With all destinations ready and the source valid every cycle, a route delivers one word per cycle.
- R10: An enabled entry whose source index is not below the input count never drives `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | Holds the fabric idle and opens the routing table for writes |
| cfg_we | input | 1 | Routing table write strobe |
| cfg_addr | input | AW | Output link index being written |
| cfg_wdata | input | SELW+1 | Enable bit on top, source input index below it |
| in_valid | input | NI | Per input link: word present |
| in_data | input | NI*W | Input words, link i in bits i*W +: W |
| in_ready | output | NI | Per input link: word accepted this cycle |
| out_valid | output | NO | Per output link: word present |
| out_data | output | NO*W | Output words, link o in bits o*W +: W |
| out_ready | input | NO | Per output link: downstream accepts |

## Verification
The bench builds the switch with three links per group and 16-bit words. That gives fifteen inputs and outputs, so the 4-bit source and address fields have exactly one value (15) past the last real link. This makes the out-of-range source case and the out-of-range address case reachable. Three links per group also let a single local input fan out to outputs in three different groups. The random phase, with frequent back-pressure and reconfiguration, therefore sees partial readiness across a branch many times.

// File: rtl/mesh_sw_pkg.sv
package mesh_sw_pkg;

  typedef enum logic [2:0] {
    GRP_NORTH = 3'd0,
    GRP_EAST  = 3'd1,
    GRP_SOUTH = 3'd2,
    GRP_WEST  = 3'd3,
    GRP_LOCAL = 3'd4
  } port_grp_e;

  localparam int NUM_GROUPS = 5;

  // total links on one side of the switch
  function automatic int link_count(input int links);
    return NUM_GROUPS * links;
  endfunction

  // flat link index of a given group and lane
  function automatic int link_index(input int grp, input int lane, input int links);
    return grp * links + lane;
  endfunction

  // width of a field that selects one of n links, never below 1
  function automatic int sel_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/mesh_sw_cfg.sv
module mesh_sw_cfg #(
  parameter int NO   = 10,
  parameter int SELW = 4,
  parameter int AW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [SELW:0]     cfg_wdata,
  output logic [NO-1:0]     route_en,
  output logic [NO*SELW-1:0] route_src
);

  logic wr_ok;
  assign wr_ok = cfg_mode && cfg_we && (int'(cfg_addr) < NO);

  for (genvar o = 0; o < NO; o++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        route_en[o]                <= 1'b0;
        route_src[o*SELW +: SELW]  <= '0;
      end else if (wr_ok && (cfg_addr == AW'(o))) begin
        route_en[o]                <= cfg_wdata[SELW];
        route_src[o*SELW +: SELW]  <= cfg_wdata[SELW-1:0];
      end
    end
  end

endmodule

// File: rtl/mesh_sw_join.sv
module mesh_sw_join #(
  parameter int NI   = 10,
  parameter int NO   = 10,
  parameter int SELW = 4
) (
  input  logic                cfg_mode,
  input  logic [NO-1:0]       route_en,
  input  logic [NO*SELW-1:0]  route_src,
  input  logic [NO-1:0]       slot_free,
  input  logic [NI-1:0]       in_valid,
  output logic [NI-1:0]       in_ready,
  output logic [NI-1:0]       fire,
  output logic [NO-1:0]       slot_load
);

  logic [NO-1:0] hit [NI];

  for (genvar i = 0; i < NI; i++) begin : g_in
    for (genvar o = 0; o < NO; o++) begin : g_out
      assign hit[i][o] = route_en[o] && (route_src[o*SELW +: SELW] == SELW'(i));
    end
    logic has_dest;
    logic blocked;
    assign has_dest    = |hit[i];
    assign blocked     = |(hit[i] & ~slot_free);
    assign in_ready[i] = !cfg_mode && has_dest && !blocked;
    assign fire[i]     = in_valid[i] && in_ready[i];
  end

  for (genvar o = 0; o < NO; o++) begin : g_load
    always_comb begin
      slot_load[o] = 1'b0;
      for (int i = 0; i < NI; i++) begin
        if (hit[i][o] && fire[i]) slot_load[o] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mesh_sw_slice.sv
module mesh_sw_slice #(
  parameter int W    = 32,
  parameter int NI   = 10,
  parameter int SELW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              route_en,
  input  logic [SELW-1:0]   route_src,
  input  logic              load,
  input  logic [NI*W-1:0]   in_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [W-1:0]      out_data,
  output logic              slot_free
);

  logic         held_v;
  logic [W-1:0] held_d;
  logic [W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NI; i++) begin
      if (route_src == SELW'(i)) pick = in_data[i*W +: W];
    end
  end

  assign slot_free = !held_v || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_v <= 1'b0;
      held_d <= '0;
    end else if (load) begin
      held_v <= 1'b1;
      held_d <= pick;
    end else if (out_ready || !route_en) begin
      held_v <= 1'b0;
    end
  end

  assign out_valid = held_v && route_en;
  assign out_data  = held_d;

endmodule

// File: rtl/mesh_route_switch.sv
module mesh_route_switch
  import mesh_sw_pkg::*;
#(
  parameter  int LINKS = 2,
  parameter  int W     = 32,
  localparam int NI    = link_count(LINKS),
  localparam int NO    = link_count(LINKS),
  localparam int SELW  = sel_bits(NI),
  localparam int AW    = sel_bits(NO)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [SELW:0]     cfg_wdata,
  input  logic [NI-1:0]     in_valid,
  input  logic [NI*W-1:0]   in_data,
  output logic [NI-1:0]     in_ready,
  output logic [NO-1:0]     out_valid,
  output logic [NO*W-1:0]   out_data,
  input  logic [NO-1:0]     out_ready
);

  logic [NO-1:0]      route_en;
  logic [NO*SELW-1:0] route_src;
  logic [NO-1:0]      slot_free;
  logic [NO-1:0]      slot_load;
  logic [NI-1:0]      fire;

  mesh_sw_cfg #(.NO(NO), .SELW(SELW), .AW(AW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .route_en  (route_en),
    .route_src (route_src)
  );

  mesh_sw_join #(.NI(NI), .NO(NO), .SELW(SELW)) u_join (
    .cfg_mode  (cfg_mode),
    .route_en  (route_en),
    .route_src (route_src),
    .slot_free (slot_free),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .fire      (fire),
    .slot_load (slot_load)
  );

  for (genvar o = 0; o < NO; o++) begin : g_slice
    mesh_sw_slice #(.W(W), .NI(NI), .SELW(SELW)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .route_en  (route_en[o]),
      .route_src (route_src[o*SELW +: SELW]),
      .load      (slot_load[o]),
      .in_data   (in_data),
      .out_ready (out_ready[o]),
      .out_valid (out_valid[o]),
      .out_data  (out_data[o*W +: W]),
      .slot_free (slot_free[o])
    );
  end

endmodule

// File: rtl/mesh_route_switch_chk.sv
module mesh_route_switch_chk #(
  parameter int NI   = 10,
  parameter int NO   = 10,
  parameter int SELW = 4,
  parameter int W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_mode,
  input logic               cfg_we,
  input logic [NI-1:0]      in_ready,
  input logic [NI*W-1:0]    in_data,
  input logic [NO-1:0]      out_valid,
  input logic [NO*W-1:0]    out_data,
  input logic [NO-1:0]      out_ready,
  input logic [NO-1:0]      route_en,
  input logic [NO*SELW-1:0] route_src,
  input logic [NI-1:0]      fire
);

  // R3: table frozen outside configuration mode
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> ($stable(route_en) && $stable(route_src)));

  // R4: idle fabric accepts nothing
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |-> (in_ready == '0));

  logic         has_dest [NI];
  logic         src_fire [NO];
  logic [W-1:0] src_data [NO];

  for (genvar i = 0; i < NI; i++) begin : g_in
    always_comb begin
      has_dest[i] = 1'b0;
      for (int o = 0; o < NO; o++) begin
        if (route_en[o] && route_src[o*SELW +: SELW] == SELW'(i)) has_dest[i] = 1'b1;
      end
    end
    // R5: source without destinations is never ready
    p_nodest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !has_dest[i] |-> !in_ready[i]);
  end

  for (genvar o = 0; o < NO; o++) begin : g_out
    always_comb begin
      src_fire[o] = 1'b0;
      src_data[o] = '0;
      for (int i = 0; i < NI; i++) begin
        if (route_en[o] && route_src[o*SELW +: SELW] == SELW'(i)) begin
          src_fire[o] = fire[i];
          src_data[o] = in_data[i*W +: W];
        end
      end
    end

    // R5: disabled output stays silent
    p_unconf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !route_en[o] |-> !out_valid[o]);

    // R6: accepted word shows up one cycle later unchanged
    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      src_fire[o] |=> (out_valid[o] && out_data[o*W +: W] == $past(src_data[o])));

    // R7: a source handshake implies this destination has room
    p_join_r7: assert property (@(posedge clk) disable iff (!rst_n)
      src_fire[o] |-> (!out_valid[o] || out_ready[o]));

    // R8: stalled word is held
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o] && !cfg_we) |=>
        (out_valid[o] && $stable(out_data[o*W +: W])));
  end

endmodule

bind mesh_route_switch mesh_route_switch_chk #(.NI(NI), .NO(NO), .SELW(SELW), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_mode  (cfg_mode),
  .cfg_we    (cfg_we),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready),
  .route_en  (route_en),
  .route_src (route_src),
  .fire      (fire)
);

// File: tb/mesh_route_switch_tb.sv
module mesh_route_switch_tb;

  localparam int LINKS = 3;
  localparam int W     = 16;
  localparam int NI    = 5 * LINKS;
  localparam int NO    = NI;
  localparam int SELW  = 4;
  localparam int AW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_mode = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [SELW:0] cfg_wdata = '0;
  logic [NI-1:0] in_valid = '0;
  logic [NI*W-1:0] in_data = '0;
  logic [NI-1:0] in_ready;
  logic [NO-1:0] out_valid;
  logic [NO*W-1:0] out_data;
  logic [NO-1:0] out_ready = '0;

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of the table and of each output slice
  logic [NO-1:0] m_en = '0;
  int            m_src [NO];
  logic [NO-1:0] m_v = '0;
  logic [W-1:0]  m_d [NO];

  mesh_route_switch #(.LINKS(LINKS), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready)
  );

  function automatic int lnk(input int grp, input int lane);
    return LINKS * grp + lane;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected ready of one input from the model
  function automatic logic exp_ready(input int i);
    logic has = 1'b0;
    logic ok = 1'b1;
    for (int o = 0; o < NO; o++) begin
      if (m_en[o] && m_src[o] == i) begin
        has = 1'b1;
        if (m_v[o] && !out_ready[o]) ok = 1'b0;
      end
    end
    return !cfg_mode && has && ok;
  endfunction

  // inputs have been driven at a falling edge; check, advance one clock
  task automatic cycle();
    logic [NI-1:0] er;
    logic [NO-1:0] nv;
    logic [W-1:0]  nd [NO];
    #1;
    for (int i = 0; i < NI; i++) er[i] = exp_ready(i);
    check("R7 in_ready", 64'(in_ready), 64'(er));
    for (int o = 0; o < NO; o++) begin
      nv[o] = m_v[o];
      nd[o] = m_d[o];
      if (m_en[o] && m_src[o] < NI && in_valid[m_src[o]] && er[m_src[o]]) begin
        nv[o] = 1'b1;
        nd[o] = in_data[m_src[o]*W +: W];
      end else if (out_ready[o] || !m_en[o]) begin
        nv[o] = 1'b0;
      end
    end
    if (cfg_mode && cfg_we && int'(cfg_addr) < NO) begin
      m_en[cfg_addr]  = cfg_wdata[SELW];
      m_src[cfg_addr] = int'(cfg_wdata[SELW-1:0]);
    end
    @(posedge clk);
    @(negedge clk);
    m_v = nv;
    for (int o = 0; o < NO; o++) m_d[o] = nd[o];
    check("R5 out_valid", 64'(out_valid), 64'(m_v & m_en));
    for (int o = 0; o < NO; o++) begin
      if (m_v[o] && m_en[o]) check("R6 out_data", 64'(out_data[o*W +: W]), 64'(m_d[o]));
    end
  endtask

  task automatic cfg_wr(input int addr, input logic en, input int src);
    cfg_we    = 1'b1;
    cfg_addr  = AW'(addr);
    cfg_wdata = {en, SELW'(src)};
    cycle();
    cfg_we    = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic seen;
    void'($urandom(32'h1234_5eed));
    for (int o = 0; o < NO; o++) begin m_src[o] = 0; m_d[o] = '0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1 out_valid", 64'(out_valid), 64'h0);
    check("R1 in_ready", 64'(in_ready), 64'h0);
    @(negedge clk);

    // R2: program routes in configuration mode
    cfg_mode = 1'b1;
    in_valid = '1;
    cfg_wr(lnk(1,0), 1'b1, lnk(3,0));   // west0 -> east0
    cfg_wr(lnk(4,0), 1'b1, lnk(0,1));   // north1 -> local0
    cfg_wr(lnk(0,2), 1'b1, lnk(4,2));   // local2 fans out
    cfg_wr(lnk(2,1), 1'b1, lnk(4,2));
    cfg_wr(lnk(3,2), 1'b1, lnk(4,2));
    cfg_wr(lnk(1,2), 1'b1, 15);         // R10 source past last link
    cfg_wr(15, 1'b1, 0);                // address past last output
    // R4: idle fabric refuses words
    out_ready = '1;
    cycle();
    check("R4 in_ready idle", 64'(in_ready), 64'h0);
    cfg_mode = 1'b0;
    in_valid = '0;
    cycle();

    // R3: write outside configuration mode is dropped
    cfg_wr(lnk(1,1), 1'b1, 0);
    in_valid[0] = 1'b1;
    cycle();
    check("R3 out_valid east1", 64'(out_valid[lnk(1,1)]), 64'h0);
    check("R3 in_ready input0", 64'(in_ready[0]), 64'h0);
    in_valid = '0;

    // R6: single word west0 -> east0
    in_valid[lnk(3,0)] = 1'b1;
    in_data[lnk(3,0)*W +: W] = 16'hBEEF;
    cycle();
    check("R6 east0 valid", 64'(out_valid[lnk(1,0)]), 64'h1);
    check("R6 east0 data", 64'(out_data[lnk(1,0)*W +: W]), 64'hBEEF);
    in_valid = '0;

    // R7: fanout word lands on all three branches
    in_valid[lnk(4,2)] = 1'b1;
    in_data[lnk(4,2)*W +: W] = 16'hA11A;
    cycle();
    check("R7 branch north2", 64'(out_valid[lnk(0,2)]), 64'h1);
    check("R7 branch south1", 64'(out_valid[lnk(2,1)]), 64'h1);
    check("R7 branch west2", 64'(out_valid[lnk(3,2)]), 64'h1);
    // one branch stalls: source must wait, others get nothing new
    out_ready[lnk(2,1)] = 1'b0;
    in_data[lnk(4,2)*W +: W] = 16'hB22B;
    #1;
    check("R7 join blocked", 64'(in_ready[lnk(4,2)]), 64'h0);
    cycle();
    check("R7 north2 no copy", 64'(out_valid[lnk(0,2)]), 64'h0);
    // R8: stalled branch holds its word
    check("R8 south1 held valid", 64'(out_valid[lnk(2,1)]), 64'h1);
    check("R8 south1 held data", 64'(out_data[lnk(2,1)*W +: W]), 64'hA11A);
    cycle();
    check("R8 south1 still held", 64'(out_data[lnk(2,1)*W +: W]), 64'hA11A);
    out_ready = '1;
    cycle();
    check("R7 branch released", 64'(out_data[lnk(0,2)*W +: W]), 64'hB22B);
    in_valid = '0;
    cycle();

    // R9: back-to-back stream
    cnt = 0;
    in_valid[lnk(3,0)] = 1'b1;
    for (int k = 0; k < 8; k++) begin
      in_data[lnk(3,0)*W +: W] = W'(16'h100 + k);
      cycle();
      if (out_valid[lnk(1,0)] && out_data[lnk(1,0)*W +: W] == W'(16'h100 + k)) cnt++;
    end
    check("R9 words delivered", 64'(cnt), 64'd8);
    in_valid = '0;

    // R10: out-of-range source never drives its output
    seen = 1'b0;
    in_valid = '1;
    for (int k = 0; k < 6; k++) begin
      cycle();
      if (out_valid[lnk(1,2)]) seen = 1'b1;
    end
    check("R10 east2 silent", 64'(seen), 64'h0);
    in_valid = '0;
    cycle();

    // random traffic with periodic reconfiguration
    for (int r = 0; r < 2400; r++) begin
      if (r % 300 == 150) begin
        in_valid = '0;
        cfg_mode = 1'b1;
        for (int k = 0; k < 6; k++) cfg_wr(int'($urandom_range(0, 15)), 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 15)));
        cfg_mode = 1'b0;
      end
      for (int i = 0; i < NI; i++) begin
        in_valid[i] = 1'($urandom_range(0, 1));
        in_data[i*W +: W] = W'($urandom);
      end
      for (int o = 0; o < NO; o++) out_ready[o] = ($urandom_range(0, 9) < 7);
      cycle();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule